// File: doc/BRIEF.md
# First-Edge Lockout Deglitcher

This block cleans up a single bouncy digital input inside a synchronous design. The raw input passes through a synchronizer. The first transition of either polarity then reaches the clean output after a fixed, short latency. There is no wait for the input to settle. Once the output has moved, a lockout timer blanks the input for a set number of clock cycles, so that bounce cannot drive the output back. When the window closes, the opposite edge is armed again.

The lockout is a single counter. A small four-state machine drives it: low and idle, high and locked, high and idle, low and locked. The output level is part of the state, so no combination of flags can leave the block stuck. When a window expires and the synchronized level differs from the output, the output takes that level at once and a fresh window starts.

A parameter selects the retriggerable mode. In that mode every change of the synchronized input during a window restarts the window. The input and output are single-level control signals, so they carry no handshake.

Top module: `edge_lockout_filter`

## Requirements
- R1: Synchronous active-low reset puts the machine in the low idle state. The output is low, the lockout counter is zero and the synchronizer flops are cleared.
- R2: With SYNC_STAGES = 2, a rising input level that is set up before clock edge k appears on `clean_out` after clock edge k+2. This is three edges in total, with no stability wait.
- R3: After any change of `clean_out`, the output holds its level for at least LOCK_CYCLES clock cycles, whatever the input does. This covers transitions of either polarity.
- R4: In the default non-retriggerable mode (RETRIG = 0), input edges inside a window do not lengthen it. The output may change again exactly LOCK_CYCLES cycles after its previous change.
- R5: When a window expires, if the synchronized level differs from the output, the output takes that level on the same edge and a new window of LOCK_CYCLES starts. Otherwise the machine returns to idle.
- R6: A falling input level, set up after the rising window has closed, drives `clean_out` low with the same three-edge latency as R2. It then starts its own window.
- R7: With RETRIG = 1, each change of the synchronized input during a window reloads the counter to LOCK_CYCLES. The output therefore changes LOCK_CYCLES + 3 edges after the last raw change that was set up before it.
- R8: The lockout counter is nonzero exactly when the machine is in a locked state. Without retriggering, every locked state leaves within LOCK_CYCLES cycles, either to idle or to the opposite locked state.
- R9: LOCK_CYCLES = 1 is legal and lets the output follow the synchronized input with one change per cycle. LOCK_CYCLES = 0 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_in | input | 1 | Asynchronous bouncy input |
| clean_out | output | 1 | Deglitched level |

## Verification
The hardest situation to reach is a window that expires while the synchronized level disagrees with the output. In retriggerable mode, it is also hard to reach a window that keeps being restarted by a sustained burst of input changes. Both depend on where input edges fall relative to a counter that cannot be seen from the ports. The stimulus therefore combines directed bursts with toggles on consecutive cycles and a pulse that ends just inside the window. Long random runs of short hold times then repeatedly land input changes on the expiry cycle. Three instances (non-retriggerable, retriggerable, and a one-cycle window) are compared each cycle against a bench model derived from the requirements.

// File: rtl/elf_pkg.sv
package elf_pkg;
  // bit 1: window active, bit 0: output level
  typedef enum logic [1:0] {
    ST_IDLE_LO = 2'b00,
    ST_IDLE_HI = 2'b01,
    ST_LOCK_LO = 2'b10,
    ST_LOCK_HI = 2'b11
  } elf_state_t;
endpackage

// File: rtl/elf_sync.sv
module elf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic chg
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];
  assign chg = lvl ^ prev;
endmodule

// File: rtl/elf_lock_timer.sv
module elf_lock_timer #(
  parameter int LOCK_CYCLES = 10,
  parameter int CW          = $clog2(LOCK_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  output logic [CW-1:0] cnt,
  output logic          last
);
  localparam logic [CW-1:0] RELOAD = CW'(LOCK_CYCLES);
  localparam logic [CW-1:0] ONE    = CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= RELOAD;
    else if (cnt != '0)   cnt <= cnt - ONE;
  end

  assign last = (cnt == ONE);
endmodule

// File: rtl/elf_fsm.sv
module elf_fsm
  import elf_pkg::*;
#(
  parameter bit RETRIG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic chg,
  input  logic last,
  output logic load,
  output logic locked,
  output logic level
);
  elf_state_t st, nxt;
  logic       restart;

  assign restart = RETRIG && chg;

  always_comb begin
    nxt  = st;
    load = 1'b0;
    if (!st[1]) begin
      if (lvl != st[0]) begin
        nxt  = elf_state_t'({1'b1, lvl});
        load = 1'b1;
      end
    end else if (restart) begin
      load = 1'b1;
    end else if (last) begin
      if (lvl != st[0]) begin
        nxt  = elf_state_t'({1'b1, lvl});
        load = 1'b1;
      end else begin
        nxt = elf_state_t'({1'b0, st[0]});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE_LO;
    else        st <= nxt;
  end

  assign locked = st[1];
  assign level  = st[0];
endmodule

// File: rtl/edge_lockout_filter.sv
module edge_lockout_filter #(
  parameter int LOCK_CYCLES = 10,
  parameter bit RETRIG      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic clean_out
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  // R9: a zero-length window is refused at elaboration
  if (LOCK_CYCLES < 1) begin : g_bad_lock
    $error("edge_lockout_filter: LOCK_CYCLES must be at least 1");
  end
  if (SYNC_STAGES < 1) begin : g_bad_sync
    $error("edge_lockout_filter: SYNC_STAGES must be at least 1");
  end

  logic          sync_lvl;
  logic          sync_chg;
  logic          lock_load;
  logic          lock_last;
  logic          locked;
  logic [CW-1:0] lock_cnt;

  elf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .lvl   (sync_lvl),
    .chg   (sync_chg)
  );

  elf_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES), .CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (lock_load),
    .cnt   (lock_cnt),
    .last  (lock_last)
  );

  elf_fsm #(.RETRIG(RETRIG)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (sync_lvl),
    .chg    (sync_chg),
    .last   (lock_last),
    .load   (lock_load),
    .locked (locked),
    .level  (clean_out)
  );
endmodule

// File: rtl/elf_checker.sv
module elf_checker #(
  parameter int LOCK_CYCLES = 10,
  parameter bit RETRIG      = 1'b0,
  parameter int CW          = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out,
  input logic          lvl,
  input logic          chg,
  input logic          locked,
  input logic          last,
  input logic [CW-1:0] cnt
);
  logic prv;
  int   gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prv <= 1'b0;
      gap <= LOCK_CYCLES;
    end else begin
      prv <= out;
      if (out != prv)            gap <= 1;
      else if (gap < LOCK_CYCLES) gap <= gap + 1;
    end
  end

  assert_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out != prv) |-> (gap >= LOCK_CYCLES));

  assert_count_matches_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked == (cnt != '0));

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && lvl != out) |=> (out == $past(lvl) && locked));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && lvl == out) |=> $stable(out));

  assert_expiry_takes_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && last && !(RETRIG && chg)) |=> (out == $past(lvl)));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (RETRIG && locked && chg) |=> (locked && cnt == CW'(LOCK_CYCLES) && $stable(out)));
endmodule

bind edge_lockout_filter elf_checker #(
  .LOCK_CYCLES (LOCK_CYCLES),
  .RETRIG      (RETRIG),
  .CW          (CW)
) u_elf_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .out    (clean_out),
  .lvl    (sync_lvl),
  .chg    (sync_chg),
  .locked (locked),
  .last   (lock_last),
  .cnt    (lock_cnt)
);

// File: tb/edge_lockout_filter_bench.sv
module edge_lockout_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw = 1'b0;
  logic [NI-1:0] outs;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // instance 0: window 6, fixed; 1: window 6, restartable; 2: window 1
  edge_lockout_filter #(.LOCK_CYCLES(6), .RETRIG(1'b0)) u_edge_lockout_filter (
    .clk(clk), .rst_n(rst_n), .raw_in(raw), .clean_out(outs[0]));
  edge_lockout_filter #(.LOCK_CYCLES(6), .RETRIG(1'b1)) u_edge_lockout_filter_rt (
    .clk(clk), .rst_n(rst_n), .raw_in(raw), .clean_out(outs[1]));
  edge_lockout_filter #(.LOCK_CYCLES(1), .RETRIG(1'b0)) u_edge_lockout_filter_one (
    .clk(clk), .rst_n(rst_n), .raw_in(raw), .clean_out(outs[2]));

  function automatic int win(int i);
    return (i == 2) ? 1 : 6;
  endfunction
  function automatic bit rst_mode(int i);
    return (i == 1);
  endfunction

  // model built from the requirements
  bit m1[NI], m2[NI], mp[NI], mo[NI], ml[NI];
  int mc[NI];
  bit prevo[NI];
  int nchg[NI];
  int last_chg[NI];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < NI; i++) begin
      if (!rst_n) begin
        m1[i] <= 0; m2[i] <= 0; mp[i] <= 0; mo[i] <= 0; ml[i] <= 0; mc[i] <= 0;
      end else begin
        m1[i] <= raw; m2[i] <= m1[i]; mp[i] <= m2[i];
        if (!ml[i]) begin
          if (m2[i] != mo[i]) begin mo[i] <= m2[i]; ml[i] <= 1; mc[i] <= win(i); end
        end else if (rst_mode(i) && m2[i] != mp[i]) begin
          mc[i] <= win(i);
        end else if (mc[i] == 1) begin
          if (m2[i] != mo[i]) begin mo[i] <= m2[i]; mc[i] <= win(i); end
          else begin ml[i] <= 0; mc[i] <= 0; end
        end else begin
          mc[i] <= mc[i] - 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NI; i++) begin
        chk(outs[i] == mo[i], (i == 2) ? "R9 one-cycle model" :
            (i == 1) ? "R7 restart model" : "R3 model", outs[i], mo[i]);
        if (outs[i] != prevo[i]) begin nchg[i]++; last_chg[i] = cyc; end
        prevo[i] = outs[i];
      end
    end else begin
      for (int i = 0; i < NI; i++) prevo[i] = outs[i];
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    int k, base_a, base_b, base_c;
    void'($urandom(32'd2024));
    tick(4);
    for (int i = 0; i < NI; i++) chk(outs[i] == 1'b0, "R1 reset level", outs[i], 0);
    rst_n = 1'b1;
    tick(4);
    for (int i = 0; i < NI; i++) chk(outs[i] == 1'b0, "R1 idle after reset", outs[i], 0);

    // R2 rising latency
    raw = 1'b1; k = cyc;
    tick(12);
    for (int i = 0; i < NI; i++) chk(last_chg[i] - k == 3, "R2 rise latency", last_chg[i] - k, 3);

    // R6 falling latency after window closed
    raw = 1'b0; k = cyc;
    tick(12);
    for (int i = 0; i < NI; i++) chk(last_chg[i] - k == 3, "R6 fall latency", last_chg[i] - k, 3);

    // R3 R4 R7 R9: rise then bounce, settle low
    base_a = nchg[0]; base_b = nchg[1]; base_c = nchg[2];
    raw = 1'b1; k = cyc;
    tick(1); raw = 1'b0;
    tick(1); raw = 1'b1;
    tick(1); raw = 1'b0;
    tick(1);
    chk(outs[0] == 1'b1, "R3 bounce ignored", outs[0], 1);
    tick(20);
    chk(nchg[0] - base_a == 2, "R3 two changes only", nchg[0] - base_a, 2);
    chk(last_chg[0] - k == 9, "R4 fall at window end", last_chg[0] - k, 9);
    chk(last_chg[1] - (k + 3) == 9, "R7 restart from last edge", last_chg[1] - (k + 3), 9);
    chk(nchg[1] - base_b == 2, "R7 two changes", nchg[1] - base_b, 2);
    chk(nchg[2] - base_c == 4, "R9 tracks every toggle", nchg[2] - base_c, 4);
    chk(last_chg[2] - (k + 3) == 3, "R9 last toggle latency", last_chg[2] - (k + 3), 3);

    // R5: expiry with differing level chains into a new window
    raw = 1'b1; k = cyc;
    tick(1); raw = 1'b0;
    tick(9); raw = 1'b1;
    tick(4);
    chk(last_chg[0] - k == 9, "R5 fall at expiry", last_chg[0] - k, 9);
    tick(4);
    chk(outs[0] == 1'b1, "R5 re-rise level", outs[0], 1);
    chk(last_chg[0] - k == 15, "R5 new window chained", last_chg[0] - k, 15);
    tick(20);

    // random bursts, checked against the model every cycle
    for (int s = 0; s < 3000; s++) begin
      raw = ~raw;
      tick($urandom_range(1, (s % 3 == 0) ? 14 : 4));
    end
    tick(20);
    chk(outs[0] == raw, "R8 settles to input", outs[0], raw);
    chk(outs[1] == raw, "R8 settles to input rt", outs[1], raw);

    // R1: reset mid-operation
    raw = 1'b1; tick(8); rst_n = 1'b0; tick(3);
    for (int i = 0; i < NI; i++) chk(outs[i] == 1'b0, "R1 reset again", outs[i], 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule